// File: doc/BRIEF.md
# Edge-Triggered Cartridge Bank Controller

This block maps the program and character ROMs of an 8-bit console cartridge, and it decodes CPU writes made anywhere in the upper half of the CPU address space. Each accepted write stores the high nibble of the written value in a 4-bit command latch. A bank register is loaded only when the command bit that guards it goes from 0 to 1, using the low data bits of that same write. Software therefore changes a bank in two writes. The first write carries the command bit together with the bank number. The second write clears the command bit so that the next bank change can produce a new edge.

The ROM drives the data bus at the same moment as the CPU. Because of this, the controller acts on the bitwise AND of the CPU byte and the ROM byte at the written address. The program side has two 16KB windows. The lower window is switchable, and the upper window always shows the last program bank. The character side has one switchable 8KB window. Two latched command bits drive the reset line and the write strobe of an external speech sample player. The low five bits of the address of the last accepted write are passed to that player as a sample index.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A cycle with `cpu_wr` high and `cpu_addr[15]` = 1 is an accepted write. On the next clock edge it stores bits 7:4 of the effective byte in the command latch, in the order program-enable (bit 7), character-enable (bit 6), sound-run (bit 5), sound-strobe (bit 4). A write with `cpu_addr[15]` = 0 changes no output.
- R2: The effective byte of a write is `cpu_data & rom_rd_data`.
- R3: When an accepted write moves the program-enable bit from 0 to 1, the program bank register takes bits 2:0 of the effective byte.
- R4: When an accepted write moves the character-enable bit from 0 to 1, the character bank register takes bits 3:0 of the effective byte. If both enable bits rise in the same write, both registers load.
- R5: A bank register keeps its value on every write in which its enable bit stays at 1, falls, or stays at 0.
- R6: When `cpu_addr[14]` = 0, `prg_addr` = {program bank, `cpu_addr[13:0]`}. When `cpu_addr[14]` = 1, `prg_addr` = {3'b111, `cpu_addr[13:0]`}.
- R7: `chr_addr` = {character bank, `ppu_addr[12:0]`}.
- R8: `snd_rst_n` follows the latched sound-run bit and `snd_wr` follows the latched sound-strobe bit. `snd_sample` holds `cpu_addr[4:0]` of the last accepted write.
- R9: After reset, the command latch, both bank registers and the sample index are zero. As a result, a first write with an enable bit set loads its bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| rom_rd_data | input | 8 | Program ROM byte at the written address |
| ppu_addr | input | 13 | Character-side address within the 8KB window |
| prg_addr | output | 17 | Program ROM address |
| chr_addr | output | 17 | Character ROM address |
| snd_rst_n | output | 1 | Active-low reset to the sample player |
| snd_wr | output | 1 | Write strobe to the sample player |
| snd_sample | output | 5 | Sample index for the sample player |

## Verification
The assertions assume that `cpu_wr` is low while reset is held. They also assume that `rom_rd_data` is stable during the cycle in which the strobe is sampled, because the effective byte is taken in that cycle. The bench drives every input on the falling clock edge and pulses `cpu_wr` for one cycle, with at least one idle cycle between writes. Random writes use a bias toward `rom_rd_data` = 8'hFF, so that most command edges pass the AND. Some writes land below the decoded range, so the ignore path is also exercised.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef struct packed {
    logic prg_en;
    logic chr_en;
    logic snd_run;
    logic snd_strobe;
  } cmd_t;

  // Two drivers share the data bus: the result is a wired-AND.
  function automatic logic [7:0] bus_merge(input logic [7:0] cpu_b, input logic [7:0] rom_b);
    return cpu_b & rom_b;
  endfunction
endpackage

// File: rtl/cbc_cmd_latch.sv
module cbc_cmd_latch
  import cbc_pkg::*;
#(
  parameter int SAMPLE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [7:0]          eff_data,
  input  logic [SAMPLE_W-1:0] addr_lo,
  output cmd_t                cmd_q,
  output logic                prg_rise,
  output logic                chr_rise,
  output logic [SAMPLE_W-1:0] smp_q
);
  cmd_t cmd_d;

  always_comb begin
    cmd_d = cmd_t'(eff_data[7:4]);
  end

  // A rise is the new nibble compared with the value already held in the latch.
  assign prg_rise = wr_hit && cmd_d.prg_en && !cmd_q.prg_en;
  assign chr_rise = wr_hit && cmd_d.chr_en && !cmd_q.chr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      smp_q <= '0;
    end else if (wr_hit) begin
      cmd_q <= cmd_d;
      smp_q <= addr_lo;
    end
  end
endmodule

// File: rtl/cbc_bank_reg.sv
module cbc_bank_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cbc_addr_gen.sv
module cbc_addr_gen #(
  parameter int PRG_BANK_W = 3,
  parameter int CHR_BANK_W = 4,
  parameter int PRG_WIN_W  = 14,
  parameter int CHR_WIN_W  = 13,
  localparam int PRG_AW    = PRG_BANK_W + PRG_WIN_W,
  localparam int CHR_AW    = CHR_BANK_W + CHR_WIN_W
) (
  input  logic [PRG_BANK_W-1:0] prg_bank,
  input  logic [CHR_BANK_W-1:0] chr_bank,
  input  logic [PRG_WIN_W:0]    cpu_lo,
  input  logic [CHR_WIN_W-1:0]  ppu_lo,
  output logic [PRG_AW-1:0]     prg_addr,
  output logic [CHR_AW-1:0]     chr_addr
);
  // The upper 16KB window is tied to the last bank of the program ROM.
  function automatic logic [PRG_AW-1:0] prg_map(input logic [PRG_BANK_W-1:0] bank,
                                                input logic [PRG_WIN_W:0] a);
    logic [PRG_BANK_W-1:0] sel;
    sel = a[PRG_WIN_W] ? {PRG_BANK_W{1'b1}} : bank;
    return {sel, a[PRG_WIN_W-1:0]};
  endfunction

  function automatic logic [CHR_AW-1:0] chr_map(input logic [CHR_BANK_W-1:0] bank,
                                                input logic [CHR_WIN_W-1:0] a);
    return {bank, a};
  endfunction

  assign prg_addr = prg_map(prg_bank, cpu_lo);
  assign chr_addr = chr_map(chr_bank, ppu_lo);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PRG_BANK_W = 3,
  parameter int CHR_BANK_W = 4,
  parameter int PRG_WIN_W  = 14,
  parameter int CHR_WIN_W  = 13,
  parameter int SAMPLE_W   = 5,
  localparam int PRG_AW    = PRG_BANK_W + PRG_WIN_W,
  localparam int CHR_AW    = CHR_BANK_W + CHR_WIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [7:0]           cpu_data,
  input  logic [7:0]           rom_rd_data,
  input  logic [CHR_WIN_W-1:0] ppu_addr,
  output logic [PRG_AW-1:0]    prg_addr,
  output logic [CHR_AW-1:0]    chr_addr,
  output logic                 snd_rst_n,
  output logic                 snd_wr,
  output logic [SAMPLE_W-1:0]  snd_sample
);
  logic                  wr_hit;
  logic [7:0]            eff_data;
  cmd_t                  cmd_q;
  logic                  prg_rise, chr_rise;
  logic [PRG_BANK_W-1:0] prg_bank;
  logic [CHR_BANK_W-1:0] chr_bank;

  assign wr_hit   = cpu_wr && cpu_addr[ADDR_W-1];
  assign eff_data = bus_merge(cpu_data, rom_rd_data);

  cbc_cmd_latch #(.SAMPLE_W(SAMPLE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .eff_data(eff_data),
    .addr_lo(cpu_addr[SAMPLE_W-1:0]), .cmd_q(cmd_q),
    .prg_rise(prg_rise), .chr_rise(chr_rise), .smp_q(snd_sample)
  );

  cbc_bank_reg #(.W(PRG_BANK_W)) u_prg_bank (
    .clk(clk), .rst_n(rst_n), .load(prg_rise),
    .d(eff_data[PRG_BANK_W-1:0]), .q(prg_bank)
  );

  cbc_bank_reg #(.W(CHR_BANK_W)) u_chr_bank (
    .clk(clk), .rst_n(rst_n), .load(chr_rise),
    .d(eff_data[CHR_BANK_W-1:0]), .q(chr_bank)
  );

  cbc_addr_gen #(
    .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
    .PRG_WIN_W(PRG_WIN_W), .CHR_WIN_W(CHR_WIN_W)
  ) u_addr (
    .prg_bank(prg_bank), .chr_bank(chr_bank),
    .cpu_lo(cpu_addr[PRG_WIN_W:0]), .ppu_lo(ppu_addr),
    .prg_addr(prg_addr), .chr_addr(chr_addr)
  );

  assign snd_rst_n = cmd_q.snd_run;
  assign snd_wr    = cmd_q.snd_strobe;
endmodule

// File: rtl/cbc_chk.sv
module cbc_chk #(
  parameter int PRG_BANK_W = 3,
  parameter int CHR_BANK_W = 4,
  parameter int PRG_WIN_W  = 14,
  parameter int PRG_AW     = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_hit,
  input logic [7:0]            eff_data,
  input logic [7:0]            cpu_data,
  input logic [7:0]            rom_rd_data,
  input logic [3:0]            cmd_bits,
  input logic                  prg_rise,
  input logic                  chr_rise,
  input logic [PRG_BANK_W-1:0] prg_bank,
  input logic [CHR_BANK_W-1:0] chr_bank,
  input logic [PRG_WIN_W:0]    cpu_lo,
  input logic [PRG_AW-1:0]     prg_addr
);
  // R1
  cmd_latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cmd_bits == $past(eff_data[7:4]));
  // R1
  cmd_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cmd_bits));
  // R2
  bus_conflict_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !rom_rd_data[7]) |=> !cmd_bits[3]);
  // R2
  bus_conflict_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !cpu_data[6]) |=> !cmd_bits[2]);
  // R3
  prg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rise |=> prg_bank == $past(eff_data[PRG_BANK_W-1:0]));
  // R4
  chr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rise |=> chr_bank == $past(eff_data[CHR_BANK_W-1:0]));
  // R5
  prg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prg_rise |=> $stable(prg_bank));
  // R5
  chr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_rise |=> $stable(chr_bank));
  // R5
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rise |-> !cmd_bits[3]);
  // R6
  fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lo[PRG_WIN_W] |-> prg_addr[PRG_AW-1:PRG_WIN_W] == {PRG_BANK_W{1'b1}});
endmodule

bind cart_bank_ctrl cbc_chk #(
  .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
  .PRG_WIN_W(PRG_WIN_W), .PRG_AW(PRG_AW)
) u_cbc_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .eff_data(eff_data),
  .cpu_data(cpu_data), .rom_rd_data(rom_rd_data), .cmd_bits(cmd_q),
  .prg_rise(prg_rise), .chr_rise(chr_rise), .prg_bank(prg_bank),
  .chr_bank(chr_bank), .cpu_lo(cpu_addr[PRG_WIN_W:0]), .prg_addr(prg_addr)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [7:0]  rom_rd_data = 8'hFF;
  logic [12:0] ppu_addr = '0;
  logic [16:0] prg_addr, chr_addr;
  logic        snd_rst_n, snd_wr;
  logic [4:0]  snd_sample;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [3:0] m_cmd = '0;
  logic [2:0] m_prg = '0;
  logic [3:0] m_chr = '0;
  logic [4:0] m_smp = '0;

  always #10 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .rom_rd_data(rom_rd_data), .ppu_addr(ppu_addr),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .snd_rst_n(snd_rst_n),
    .snd_wr(snd_wr), .snd_sample(snd_sample)
  );

  function automatic logic [16:0] exp_prg(input logic [2:0] bank, input logic [15:0] a);
    if (a[14]) return {3'b111, a[13:0]};
    return {bank, a[13:0]};
  endfunction

  function automatic logic [16:0] exp_chr(input logic [3:0] bank, input logic [12:0] a);
    return {bank, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
    logic [7:0] e;
    logic [3:0] nc;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d; rom_rd_data = r;
    @(negedge clk);
    cpu_wr = 1'b0;
    e = d & r;
    if (a[15]) begin
      nc = e[7:4];
      if (nc[3] && !m_cmd[3]) m_prg = e[2:0];
      if (nc[2] && !m_cmd[2]) m_chr = e[3:0];
      m_cmd = nc;
      m_smp = a[4:0];
    end
  endtask

  task automatic probe(input string tag);
    logic [15:0] pa;
    pa = 16'h8000 | 16'($urandom_range(0, 16'h3FFF));
    cpu_addr = pa; ppu_addr = 13'($urandom);
    #1;
    check({tag, " R6 low window"}, 32'(prg_addr), 32'(exp_prg(m_prg, pa)));
    cpu_addr = pa | 16'h4000;
    #1;
    check({tag, " R6 fixed window"}, 32'(prg_addr), 32'(exp_prg(m_prg, pa | 16'h4000)));
    check({tag, " R7 chr"}, 32'(chr_addr), 32'(exp_chr(m_chr, ppu_addr)));
    check({tag, " R8 sound"}, {29'd0, snd_rst_n, snd_wr, 1'b0}, {29'd0, m_cmd[1], m_cmd[0], 1'b0});
    check({tag, " R8 sample"}, 32'(snd_sample), 32'(m_smp));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    probe("R9 reset");
    // R4 two-write sequence selecting character bank 3
    do_write(16'h8000, 8'h43, 8'hFF); probe("R4 set");
    do_write(16'h8000, 8'h03, 8'hFF); probe("R4 clear");
    check("R4 chr bank 3", 32'(chr_addr[16:13]), 32'd3);
    // R5 enable already high: no reload
    do_write(16'h9000, 8'h85, 8'hFF);
    do_write(16'h9000, 8'h82, 8'hFF); probe("R5 held high");
    check("R3 prg bank 5", 32'(m_prg), 32'd5);
    // R4 both rise together
    do_write(16'hA000, 8'h00, 8'hFF);
    do_write(16'hA000, 8'hC6, 8'hFF); probe("R4 both");
    // R2 conflict masks the rising bit
    do_write(16'hB000, 8'h00, 8'hFF);
    do_write(16'hB000, 8'hC1, 8'h3F); probe("R2 mask");
    // R1 write below decoded range is ignored
    do_write(16'h7FFF, 8'hF7, 8'hFF); probe("R1 ignore");
    // R8 sound lines and sample index
    do_write(16'hC01B, 8'h30, 8'hFF); probe("R8 run");
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  r;
      a = 16'($urandom);
      r = ($urandom_range(0, 3) != 0) ? 8'hFF : 8'($urandom);
      do_write(a, 8'($urandom), r);
      if (i % 4 == 0) probe("R1/R3/R4/R5 random");
    end
    probe("R3/R4 final");
    finish_up();
  end
endmodule